// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This control block sits beside the pipeline of a small 32-bit RISC core and decides, cycle by cycle, whether the core leaves its normal instruction flow. Six event sources can request entry: a qualified core reset, a hardware exception, a non-maskable break, a maskable break, the single external interrupt line, and a user-vector trap. When one is taken, the block issues a redirect to a fixed low vector address. It writes the return address into a general register chosen by the event class, kills the instruction in decode, and updates the machine status word.

Nested entry is governed by status bits instead of a hardware stack. The return-from-interrupt, return-from-break and return-from-exception strobes from decode undo the matching status bit, restore the previous privilege mode, and redirect to the return target read by the pipeline. Any arbitration among several interrupt sources happens outside the block. The pipeline, the register file and the status-register consumers are not part of this block.

Top module: `exc_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, every pulse output and `rf_waddr`/`rf_wdata`/`redir_addr` become zero and `status` loads parameter `RESET_STATUS`. Status fields: bit 1 interrupt enable (IE), bit 3 break in progress (BIP), bit 9 exception in progress (EIP), bit 11 privileged (PRIV), bit 12 saved privilege (PPRIV).
- R2: `core_rst_req` is honoured only on the 16th (`RST_HOLD`) and every later consecutive cycle it is high. It then redirects to 0x00000000, kills decode, pulses `aux_clr`, writes no register and loads `RESET_STATUS`. A pulse of fewer than 16 cycles has no effect.
- R3: At most one event is taken per cycle, in fixed priority: reset, hardware exception, non-maskable break, break, interrupt, user trap. A request that is still high afterwards is taken in a later cycle if it is still eligible.
- R4: The interrupt is eligible only while IE is 1 and both BIP and EIP are 0.
- R5: A taken interrupt redirects to 0x10, writes `id_pc` to register 14, kills decode and clears IE.
- R6: A taken non-maskable or maskable break redirects to 0x18, writes `id_pc` to register 16 and sets BIP. A maskable break is ignored while BIP is 1; a non-maskable break is not.
- R7: A taken hardware exception redirects to 0x20, writes `ex_pc` to register 17 and sets EIP.
- R8: A taken user trap redirects to 0x08 and writes `ex_pc` to register 15.
- R9: Every non-reset entry sets PRIV and copies its prior value into PPRIV.
- R10: With no event taken, `ret_int` sets IE, `ret_brk` clears BIP and `ret_exc` clears EIP. Each restores PRIV from PPRIV and redirects to `ret_target` with no register write and no kill. A return strobe in a cycle where an event is taken is ignored.
- R11: All outputs are registered. A request sampled at one edge shows on the outputs after that edge, the pulse outputs last one cycle per taken event, and `status` changes only together with a redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| core_rst_req | input | 1 | Core reset request, must be held 16 cycles |
| hw_exc_req | input | 1 | Hardware exception request (level) |
| nmi_brk_req | input | 1 | Non-maskable break request (level) |
| brk_req | input | 1 | Maskable hardware or software break request (level) |
| irq_req | input | 1 | External interrupt line (level) |
| trap_req | input | 1 | User-vector trap request (level) |
| ex_pc | input | AW | PC of the instruction in execute |
| id_pc | input | AW | PC of the instruction in decode |
| ret_int | input | 1 | Return-from-interrupt decoded |
| ret_brk | input | 1 | Return-from-break decoded |
| ret_exc | input | 1 | Return-from-exception decoded |
| ret_target | input | AW | Return address read from the link register |
| redir_valid | output | 1 | Fetch redirect pulse |
| redir_addr | output | AW | Redirect target address |
| kill_id | output | 1 | Kill the instruction in decode |
| rf_we | output | 1 | Link register write enable |
| rf_waddr | output | 5 | Link register index |
| rf_wdata | output | AW | Return address written |
| aux_clr | output | 1 | Clear exception address, exception status and FPU status registers |
| status | output | 32 | Machine status word |

## Verification
The assertions assume that the pipeline raises at most one return strobe per cycle, and that each request is level-held while it wants service. They also assume that `ret_target` is meaningful only alongside a strobe. The stimulus drives returns one at a time, except in the deliberate case where a return coincides with an event. It holds requests across several cycles so that ordering and re-taking can be seen. It covers reset pulses of exactly 15 and 16 cycles, breaks and interrupts arriving while BIP is set, and all sources raised together, and it runs with a reset status that has PRIV cleared so that privilege restore is visible.

// File: rtl/exc_seq_pkg.sv
// Shared constants for the exception sequencer: event order, status field
// positions and the per-event vector and link register tables.
package exc_seq_pkg;
    localparam int NEV = 6;
    localparam int EVW = $clog2(NEV);
    localparam int SW  = 32;
    localparam int RW  = 5;

    // Event index equals priority rank (0 = highest).
    localparam int EV_RST  = 0;
    localparam int EV_HW   = 1;
    localparam int EV_NMI  = 2;
    localparam int EV_BRK  = 3;
    localparam int EV_IRQ  = 4;
    localparam int EV_TRAP = 5;

    // Status word bit positions.
    localparam int SB_IE    = 1;
    localparam int SB_BIP   = 3;
    localparam int SB_EIP   = 9;
    localparam int SB_PRIV  = 11;
    localparam int SB_PPRIV = 12;

    typedef logic [NEV-1:0] ev_vec_t;
    typedef logic [EVW-1:0] ev_idx_t;

    // Vector address for a taken event.
    function automatic logic [31:0] vec_addr(input ev_idx_t idx);
        case (idx)
            ev_idx_t'(EV_HW):   return 32'h0000_0020;
            ev_idx_t'(EV_NMI):  return 32'h0000_0018;
            ev_idx_t'(EV_BRK):  return 32'h0000_0018;
            ev_idx_t'(EV_IRQ):  return 32'h0000_0010;
            ev_idx_t'(EV_TRAP): return 32'h0000_0008;
            default:            return 32'h0000_0000;
        endcase
    endfunction

    // Link register index for a taken event (0 = no write).
    function automatic logic [RW-1:0] link_reg(input ev_idx_t idx);
        case (idx)
            ev_idx_t'(EV_HW):   return RW'(17);
            ev_idx_t'(EV_NMI):  return RW'(16);
            ev_idx_t'(EV_BRK):  return RW'(16);
            ev_idx_t'(EV_IRQ):  return RW'(14);
            ev_idx_t'(EV_TRAP): return RW'(15);
            default:            return RW'(0);
        endcase
    endfunction
endpackage

// File: rtl/exc_rst_qual.sv
// Reset request qualifier: fires on the HOLD-th and later consecutive cycles
// that the request is high. Assumes the request is synchronous to clk.
module exc_rst_qual #(
    parameter int unsigned HOLD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic fire
);
    localparam int unsigned CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

    logic [CW-1:0] run_q;

    // Combinational qualification of the current sample.
    assign fire = req && (run_q >= LAST);

    // Count consecutive high samples, saturating at HOLD-1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (!req)
            run_q <= '0;
        else if (run_q < LAST)
            run_q <= run_q + CW'(1);
    end
endmodule

// File: rtl/exc_pri_sel.sv
// Fixed-priority selector: bit 0 wins. Produces a one-hot grant, a flag that
// any request won, and the binary index of the winner.
module exc_pri_sel #(
    parameter int unsigned N  = 6,
    parameter int unsigned IW = 3
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic          any,
    output logic [IW-1:0] idx
);
    logic [N:0] blk;

    assign blk[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign gnt[i]   = req[i] & ~blk[i];
        assign blk[i+1] = blk[i] | req[i];
    end

    assign any = blk[N];

    // Encode the one-hot grant to an index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < int'(N); i++)
            if (gnt[i]) idx = IW'(i);
    end
endmodule

// File: rtl/exc_status_reg.sv
// Machine status word: loads the reset value on a qualified reset, applies
// entry side effects for the granted event, or applies return side effects.
// Assumes take and ret_any are never both high (the top guarantees it).
module exc_status_reg
    import exc_seq_pkg::*;
#(
    parameter logic [SW-1:0] RESET_STATUS = 32'h0000_0800
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ev_vec_t       gnt,
    input  logic          take,
    input  logic          ret_any,
    input  logic          ret_int,
    input  logic          ret_brk,
    input  logic          ret_exc,
    output logic [SW-1:0] status
);
    logic [SW-1:0] nxt;

    // Next status word from the granted event or return strobes.
    always_comb begin
        nxt = status;
        if (gnt[EV_RST]) begin
            nxt = RESET_STATUS;
        end else if (take) begin
            nxt[SB_PPRIV] = status[SB_PRIV];
            nxt[SB_PRIV]  = 1'b1;
            if (gnt[EV_HW])                nxt[SB_EIP] = 1'b1;
            if (gnt[EV_NMI] | gnt[EV_BRK]) nxt[SB_BIP] = 1'b1;
            if (gnt[EV_IRQ])               nxt[SB_IE]  = 1'b0;
        end else if (ret_any) begin
            nxt[SB_PRIV] = status[SB_PPRIV];
            if (ret_int) nxt[SB_IE]  = 1'b1;
            if (ret_brk) nxt[SB_BIP] = 1'b0;
            if (ret_exc) nxt[SB_EIP] = 1'b0;
        end
    end

    // Status register update.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= RESET_STATUS;
        else        status <= nxt;
    end
endmodule

// File: rtl/exc_sequencer.sv
// Exception and interrupt entry sequencer. Gates each event source by the
// status word, picks the highest-priority eligible one, and registers the
// redirect, link write, decode kill and status update. Assumes requests are
// level-held and at most one return strobe arrives per cycle.
module exc_sequencer
    import exc_seq_pkg::*;
#(
    parameter int unsigned   AW           = 32,
    parameter int unsigned   RST_HOLD     = 16,
    parameter logic [SW-1:0] RESET_STATUS = 32'h0000_0800
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          core_rst_req,
    input  logic          hw_exc_req,
    input  logic          nmi_brk_req,
    input  logic          brk_req,
    input  logic          irq_req,
    input  logic          trap_req,
    input  logic [AW-1:0] ex_pc,
    input  logic [AW-1:0] id_pc,
    input  logic          ret_int,
    input  logic          ret_brk,
    input  logic          ret_exc,
    input  logic [AW-1:0] ret_target,
    output logic          redir_valid,
    output logic [AW-1:0] redir_addr,
    output logic          kill_id,
    output logic          rf_we,
    output logic [RW-1:0] rf_waddr,
    output logic [AW-1:0] rf_wdata,
    output logic          aux_clr,
    output logic [SW-1:0] status
);
    logic    rst_fire;
    ev_vec_t elig;
    ev_vec_t gnt;
    logic    take;
    ev_idx_t win;
    logic    ret_any;
    logic    st_ie, st_bip, st_eip;

    exc_rst_qual #(.HOLD(RST_HOLD)) u_rstq (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (core_rst_req),
        .fire  (rst_fire)
    );

    assign st_ie  = status[SB_IE];
    assign st_bip = status[SB_BIP];
    assign st_eip = status[SB_EIP];

    // Eligibility of each source under the current status word.
    always_comb begin
        elig          = '0;
        elig[EV_RST]  = rst_fire;
        elig[EV_HW]   = hw_exc_req;
        elig[EV_NMI]  = nmi_brk_req;
        elig[EV_BRK]  = brk_req & ~st_bip;
        elig[EV_IRQ]  = irq_req & st_ie & ~st_bip & ~st_eip;
        elig[EV_TRAP] = trap_req;
    end

    exc_pri_sel #(.N(NEV), .IW(EVW)) u_sel (
        .req (elig),
        .gnt (gnt),
        .any (take),
        .idx (win)
    );

    assign ret_any = ~take & (ret_int | ret_brk | ret_exc);

    exc_status_reg #(.RESET_STATUS(RESET_STATUS)) u_st (
        .clk     (clk),
        .rst_n   (rst_n),
        .gnt     (gnt),
        .take    (take),
        .ret_any (ret_any),
        .ret_int (ret_int),
        .ret_brk (ret_brk),
        .ret_exc (ret_exc),
        .status  (status)
    );

    // Registered redirect, link write, kill and clear pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_valid <= 1'b0;
            redir_addr  <= '0;
            kill_id     <= 1'b0;
            rf_we       <= 1'b0;
            rf_waddr    <= '0;
            rf_wdata    <= '0;
            aux_clr     <= 1'b0;
        end else begin
            redir_valid <= take | ret_any;
            redir_addr  <= take ? AW'(vec_addr(win)) : (ret_any ? ret_target : '0);
            kill_id     <= take;
            rf_we       <= take & ~gnt[EV_RST];
            rf_waddr    <= (take & ~gnt[EV_RST]) ? link_reg(win) : '0;
            if (gnt[EV_HW] | gnt[EV_TRAP])
                rf_wdata <= ex_pc;
            else if (gnt[EV_NMI] | gnt[EV_BRK] | gnt[EV_IRQ])
                rf_wdata <= id_pc;
            else
                rf_wdata <= '0;
            aux_clr     <= gnt[EV_RST];
        end
    end
endmodule

// File: rtl/exc_seq_chk.sv
// Assertion checker for the exception sequencer, bound to every instance.
// Tracks consecutive core reset request cycles with its own counter.
module exc_seq_chk #(
    parameter int unsigned AW       = 32,
    parameter int unsigned RST_HOLD = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          core_rst_req,
    input logic          redir_valid,
    input logic [AW-1:0] redir_addr,
    input logic          kill_id,
    input logic          rf_we,
    input logic [4:0]    rf_waddr,
    input logic          aux_clr,
    input logic [31:0]   status
);
    localparam int unsigned CW = $clog2(RST_HOLD + 1) + 1;
    logic [CW-1:0] run;

    // Count consecutive reset request samples, saturating at RST_HOLD.
    always_ff @(posedge clk) begin
        if (!rst_n)                  run <= '0;
        else if (!core_rst_req)      run <= '0;
        else if (run < CW'(RST_HOLD)) run <= run + CW'(1);
    end

    AST_RST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        aux_clr |-> (run >= CW'(RST_HOLD))); // R2
    AST_RST_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        aux_clr |-> (redir_valid && kill_id && !rf_we && redir_addr == '0)); // R2
    AST_WRITE_WITH_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (redir_valid && kill_id)); // R3
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && rf_waddr == 5'd14) |-> ($past(status[1]) && !$past(status[3]) && !$past(status[9]))); // R4
    AST_IRQ_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && rf_waddr == 5'd14) |-> (!status[1] && redir_addr == AW'(32'h10))); // R5
    AST_BRK_SETS_BIP: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && rf_waddr == 5'd16) |-> status[3]); // R6
    AST_EXC_SETS_EIP: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && rf_waddr == 5'd17) |-> status[9]); // R7
    AST_ENTRY_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> status[11]); // R9
    AST_RET_NO_KILL: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_valid && !kill_id) |-> (!rf_we && !aux_clr)); // R10
    AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !redir_valid |-> $stable(status)); // R11
endmodule

bind exc_sequencer exc_seq_chk #(.AW(AW), .RST_HOLD(RST_HOLD)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .core_rst_req (core_rst_req),
    .redir_valid  (redir_valid),
    .redir_addr   (redir_addr),
    .kill_id      (kill_id),
    .rf_we        (rf_we),
    .rf_waddr     (rf_waddr),
    .aux_clr      (aux_clr),
    .status       (status)
);

// File: tb/exc_sequencer_test.sv
module exc_sequencer_test;
    localparam int          HOLD = 16;
    localparam logic [31:0] RSTV = 32'h0000_4000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic core_rst_req = 0, hw_exc_req = 0, nmi_brk_req = 0, brk_req = 0;
    logic irq_req = 0, trap_req = 0, ret_int = 0, ret_brk = 0, ret_exc = 0;
    logic [31:0] ex_pc = 0, id_pc = 0, ret_target = 0;
    logic        redir_valid, kill_id, rf_we, aux_clr;
    logic [31:0] redir_addr, rf_wdata, status;
    logic [4:0]  rf_waddr;

    int tests = 0, fails = 0;
    bit done = 0;

    // Reference model state
    int          m_hold = 0;
    logic [31:0] m_st = RSTV;
    logic        m_rv = 0, m_kill = 0, m_we = 0, m_clr = 0;
    logic [31:0] m_ra = 0, m_wd = 0;
    logic [4:0]  m_wa = 0;

    exc_sequencer #(.AW(32), .RST_HOLD(HOLD), .RESET_STATUS(RSTV)) uut (
        .clk(clk), .rst_n(rst_n), .core_rst_req(core_rst_req),
        .hw_exc_req(hw_exc_req), .nmi_brk_req(nmi_brk_req), .brk_req(brk_req),
        .irq_req(irq_req), .trap_req(trap_req), .ex_pc(ex_pc), .id_pc(id_pc),
        .ret_int(ret_int), .ret_brk(ret_brk), .ret_exc(ret_exc),
        .ret_target(ret_target), .redir_valid(redir_valid), .redir_addr(redir_addr),
        .kill_id(kill_id), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .aux_clr(aux_clr), .status(status)
    );

    always #5 clk = ~clk;

    // Behavioural model of one clock edge, using the inputs held across it.
    task automatic model_edge();
        logic fire, ie, bip, eip;
        int   ev;
        fire = core_rst_req && (m_hold >= HOLD - 1);
        ie = m_st[1]; bip = m_st[3]; eip = m_st[9];
        m_rv = 0; m_kill = 0; m_we = 0; m_clr = 0; m_ra = 0; m_wd = 0; m_wa = 0;
        if (!rst_n) begin
            m_st = RSTV; m_hold = 0;
            return;
        end
        if (fire) ev = 0;
        else if (hw_exc_req) ev = 1;
        else if (nmi_brk_req) ev = 2;
        else if (brk_req && !bip) ev = 3;
        else if (irq_req && ie && !bip && !eip) ev = 4;
        else if (trap_req) ev = 5;
        else ev = -1;
        if (ev == 0) begin
            m_rv = 1; m_kill = 1; m_clr = 1; m_ra = 0; m_st = RSTV;
        end else if (ev > 0) begin
            m_rv = 1; m_kill = 1; m_we = 1;
            m_st[12] = m_st[11]; m_st[11] = 1;
            case (ev)
                1: begin m_ra = 32'h20; m_wa = 17; m_wd = ex_pc; m_st[9] = 1; end
                2, 3: begin m_ra = 32'h18; m_wa = 16; m_wd = id_pc; m_st[3] = 1; end
                4: begin m_ra = 32'h10; m_wa = 14; m_wd = id_pc; m_st[1] = 0; end
                default: begin m_ra = 32'h08; m_wa = 15; m_wd = ex_pc; end
            endcase
        end else if (ret_int || ret_brk || ret_exc) begin
            m_rv = 1; m_ra = ret_target; m_st[11] = m_st[12];
            if (ret_int) m_st[1] = 1;
            if (ret_brk) m_st[3] = 0;
            if (ret_exc) m_st[9] = 0;
        end
        if (!core_rst_req) m_hold = 0;
        else if (m_hold < HOLD - 1) m_hold++;
    endtask

    // Advance one clock and compare every output with the model.
    task automatic tick(input string tag);
        @(posedge clk);
        model_edge();
        #1;
        tests++;
        if ({redir_valid, kill_id, rf_we, aux_clr} !== {m_rv, m_kill, m_we, m_clr} ||
            redir_addr !== m_ra || rf_waddr !== m_wa || rf_wdata !== m_wd || status !== m_st) begin
            fails++;
            $display("FAIL %s t=%0t actual rv=%b kill=%b we=%b clr=%b addr=%h wa=%0d wd=%h st=%h expected rv=%b kill=%b we=%b clr=%b addr=%h wa=%0d wd=%h st=%h",
                     tag, $time, redir_valid, kill_id, rf_we, aux_clr, redir_addr, rf_waddr, rf_wdata, status,
                     m_rv, m_kill, m_we, m_clr, m_ra, m_wa, m_wd, m_st);
        end
    endtask

    task automatic clear_in();
        {core_rst_req, hw_exc_req, nmi_brk_req, brk_req, irq_req, trap_req} = '0;
        {ret_int, ret_brk, ret_exc} = '0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        ex_pc = 32'h0000_00FC; id_pc = 32'h0000_0100; ret_target = 32'h0000_1234;
        // R1: block reset state
        repeat (3) tick("R1");
        rst_n = 1;
        tick("R11");
        // R10: return from interrupt enables interrupts
        ret_int = 1; tick("R10"); clear_in();
        // R5: interrupt entry; R4: held request blocked after IE clears
        irq_req = 1; id_pc = 32'h0000_0200; tick("R5"); tick("R4"); clear_in();
        ret_target = 32'h0000_0204; ret_int = 1; tick("R10"); clear_in();
        // R6: break entry, then break and interrupt blocked by BIP
        brk_req = 1; id_pc = 32'h0000_0300; tick("R6");
        irq_req = 1; tick("R4"); tick("R6"); clear_in();
        // R6: non-maskable break still taken while BIP set; R9 privilege save
        nmi_brk_req = 1; id_pc = 32'h0000_0310; tick("R6"); clear_in();
        ret_target = 32'h0000_0314; ret_brk = 1; tick("R10"); clear_in();
        // R7: hardware exception, R4 interrupt blocked by EIP, then return
        hw_exc_req = 1; ex_pc = 32'h0000_0400; tick("R7"); clear_in();
        irq_req = 1; tick("R4"); clear_in();
        ret_target = 32'h0000_0404; ret_exc = 1; tick("R10"); clear_in();
        // R8: user trap; R9: privilege restored by return
        trap_req = 1; ex_pc = 32'h0000_0500; tick("R8"); clear_in();
        ret_target = 32'h0000_0504; ret_exc = 1; tick("R9"); clear_in();
        // R10: return ignored when an event is taken in the same cycle
        ret_int = 1; trap_req = 1; tick("R10"); clear_in();
        tick("R11");
        // R3: everything but reset raised together, then withdrawn in order
        hw_exc_req = 1; nmi_brk_req = 1; brk_req = 1; irq_req = 1; trap_req = 1;
        tick("R3"); tick("R3");
        hw_exc_req = 0; tick("R3");
        nmi_brk_req = 0; tick("R3"); tick("R3");
        clear_in(); tick("R11");
        // R2: fifteen-cycle reset pulse is ignored
        core_rst_req = 1;
        for (int i = 0; i < HOLD - 1; i++) tick("R2");
        core_rst_req = 0; tick("R2");
        // R2: sixteen cycles honoured, and again while held
        core_rst_req = 1;
        for (int i = 0; i < HOLD + 2; i++) tick("R2");
        // R3: reset outranks a hardware exception
        hw_exc_req = 1; tick("R3");
        clear_in(); tick("R11"); tick("R11");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule